// File: doc/BRIEF.md
# Tile Spare Configuration Selector

This block picks one precomputed placement per tile of a regular logic array, so that a full device configuration can be assembled without re-running placement for each part. The array is cut into square tiles of K by K cells. Each tile leaves one cell unused as a spare, and K² placements exist for it. Placement p leaves cell p of the tile empty. Given the defect map of the whole array, the block walks the tiles and reports, for each one, which placement steers around its faulty cell.

A tile with two or more faulty cells has no usable placement. Such a tile is flagged as unrepairable even when spares elsewhere in the array are unused, because repair never crosses a tile boundary. A scan starts on a pulse, and the defect map must stay still while the scan runs. Each result leaves as a tile number, a placement index and a bad flag, under a valid/ready handshake. When the last result has been taken, the block reports whether any tile failed and how many did.

Top module: `tile_spare_selector`

## Requirements
- R1: After reset, out_valid, busy, done, any_fail and fail_count are all 0.
- R2: Results leave in row-major tile order. Tile id t = ty*TILES_X + tx covers array rows ty*K to ty*K+K-1 and columns tx*K to tx*K+K-1. Cell (row, col) of the array is defect_map bit row*(TILES_X*K)+col, and 1 means faulty.
- R3: A tile with exactly one faulty cell, at local row r and column c, reports out_variant = r*K+c with out_bad = 0.
- R4: A tile with no faulty cell reports out_variant = 0 with out_bad = 0.
- R5: A tile with two or more faulty cells reports out_bad = 1 with out_variant = 0, whatever the other tiles hold.
- R6: While out_valid is 1 and out_ready is 0, out_tile, out_variant and out_bad hold their values, and out_valid stays 1.
- R7: At done, fail_count equals the number of tiles reported with out_bad = 1 in that scan, and any_fail is 1 exactly when that number is nonzero.
- R8: busy is 1 from the cycle after an accepted start until the last result is taken, and then done becomes 1. A start that arrives while busy is ignored.
- R9: An accepted start clears done, any_fail and fail_count.
- R10: With out_ready held at 1, results appear on consecutive cycles, with no gap between the first tile and the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a scan when idle |
| defect_map | input | TILES_Y*K*TILES_X*K | Per-cell fault bitmap, held during a scan |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_tile | output | clog2(tiles) | Row-major tile id |
| out_variant | output | clog2(K*K) | Chosen placement index |
| out_bad | output | 1 | Tile cannot be repaired |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Last result taken |
| any_fail | output | 1 | Some tile was unrepairable |
| fail_count | output | clog2(tiles+1) | Number of unrepairable tiles |

## Verification
The consumer taking one result and the scan loading the next tile into the same output slot can happen in the same cycle. This is provoked by holding out_ready high, so that every handshake is also a load. The bench judges it by requiring each tile id to appear once, in order, with no idle cycle between results. It also alternates out_ready, so that loads fall on cycles both with and without a take, and checks that stalled results stay still. A second start sent in the middle of a scan checks that the sequence and the fail totals are left unchanged.

// File: rtl/tsel_pkg.sv
// Shared types for the tile spare selector.
// Assumes: nothing beyond standard SystemVerilog.
package tsel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2
    } scan_state_e;
endpackage

// File: rtl/tsel_tile_gather.sv
// Picks the K*K fault bits of one tile out of the full array map, in
// row-major order inside the tile.
// Assumes: map bit index is row*COLS+col; tile ids are row-major over tiles.
module tsel_tile_gather #(
    parameter int K       = 2,
    parameter int TILES_X = 4,
    parameter int TILES_Y = 4,
    localparam int COLS   = TILES_X * K,
    localparam int ROWS   = TILES_Y * K,
    localparam int NT     = TILES_X * TILES_Y,
    localparam int TW     = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic [ROWS*COLS-1:0] cell_map,
    input  logic [TW-1:0]        tile_id,
    output logic [K*K-1:0]       tile_bits
);
    int tile_x;
    int tile_y;

    // Split the tile id into tile column and tile row.
    always_comb begin
        tile_x = int'(tile_id) % TILES_X;
        tile_y = int'(tile_id) / TILES_X;
    end

    for (genvar r = 0; r < K; r++) begin : g_row
        for (genvar c = 0; c < K; c++) begin : g_col
            assign tile_bits[r*K+c] = cell_map[(tile_y*K + r)*COLS + tile_x*K + c];
        end
    end
endmodule

// File: rtl/tsel_defect_encoder.sv
// Counts faulty cells in a tile and encodes the placement index.
// Zero faults give index 0, one fault gives its position, more give bad.
// Assumes: N_CELL >= 2.
module tsel_defect_encoder #(
    parameter int N_CELL = 4,
    localparam int VW    = $clog2(N_CELL),
    localparam int CW    = $clog2(N_CELL + 1)
) (
    input  logic [N_CELL-1:0] bits,
    output logic [VW-1:0]     variant,
    output logic              bad
);
    logic [CW-1:0] fault_cnt;
    logic [VW-1:0] first_pos;
    logic          found;

    // Count faults and remember the lowest faulty position.
    always_comb begin
        fault_cnt = '0;
        first_pos = '0;
        found     = 1'b0;
        for (int i = 0; i < N_CELL; i++) begin
            if (bits[i]) begin
                fault_cnt = fault_cnt + 1'b1;
                if (!found) first_pos = VW'(i);
                found = 1'b1;
            end
        end
    end

    // Choose the result: a single fault selects its own placement.
    always_comb begin
        bad     = (fault_cnt > CW'(1));
        variant = bad ? '0 : first_pos;
    end
endmodule

// File: rtl/tile_spare_selector.sv
// Scans all tiles in row-major order and streams one placement choice per
// tile through a valid/ready slot, keeping a total of unrepairable tiles.
// Assumes: defect_map is stable from start until done; K >= 2; tiles >= 2.
module tile_spare_selector
    import tsel_pkg::*;
#(
    parameter int K       = 2,
    parameter int TILES_X = 4,
    parameter int TILES_Y = 4,
    localparam int COLS   = TILES_X * K,
    localparam int ROWS   = TILES_Y * K,
    localparam int NT     = TILES_X * TILES_Y,
    localparam int N_CELL = K * K,
    localparam int TW     = $clog2(NT),
    localparam int VW     = $clog2(N_CELL),
    localparam int FW     = $clog2(NT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ROWS*COLS-1:0] defect_map,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [TW-1:0]        out_tile,
    output logic [VW-1:0]        out_variant,
    output logic                 out_bad,
    output logic                 busy,
    output logic                 done,
    output logic                 any_fail,
    output logic [FW-1:0]        fail_count
);
    scan_state_e       state_q;
    logic [TW-1:0]     tile_q;
    logic [N_CELL-1:0] cur_bits;
    logic [VW-1:0]     enc_variant;
    logic              enc_bad;
    logic              take;
    logic              load;
    logic              last_tile;

    tsel_tile_gather #(.K(K), .TILES_X(TILES_X), .TILES_Y(TILES_Y)) u_gather (
        .cell_map  (defect_map),
        .tile_id   (tile_q),
        .tile_bits (cur_bits)
    );

    tsel_defect_encoder #(.N_CELL(N_CELL)) u_enc (
        .bits    (cur_bits),
        .variant (enc_variant),
        .bad     (enc_bad)
    );

    // Handshake and load conditions for the single output slot.
    always_comb begin
        take      = out_valid && out_ready;
        load      = (state_q == ST_SCAN) && (!out_valid || out_ready);
        last_tile = (tile_q == TW'(NT - 1));
    end

    // Scan sequencer, output slot and fail totals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            tile_q      <= '0;
            out_valid   <= 1'b0;
            out_tile    <= '0;
            out_variant <= '0;
            out_bad     <= 1'b0;
            busy        <= 1'b0;
            done        <= 1'b0;
            any_fail    <= 1'b0;
            fail_count  <= '0;
        end else begin
            if (take) out_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q    <= ST_SCAN;
                        tile_q     <= '0;
                        busy       <= 1'b1;
                        done       <= 1'b0;
                        any_fail   <= 1'b0;
                        fail_count <= '0;
                    end
                end
                ST_SCAN: begin
                    if (load) begin
                        out_valid   <= 1'b1;
                        out_tile    <= tile_q;
                        out_variant <= enc_variant;
                        out_bad     <= enc_bad;
                        if (enc_bad) begin
                            fail_count <= fail_count + 1'b1;
                            any_fail   <= 1'b1;
                        end
                        if (last_tile) state_q <= ST_DRAIN;
                        else           tile_q  <= tile_q + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (take) begin
                        state_q <= ST_IDLE;
                        busy    <= 1'b0;
                        done    <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tile) &&
                                       $stable(out_variant) && $stable(out_bad)));

    // R2
    tile_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid || out_tile == TW'($past(out_tile) + 1'b1)));

    // R5
    bad_variant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bad) |-> (out_variant == '0));

    // R8
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R8
    valid_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_count <= FW'(NT));
endmodule

// File: tb/tb_tile_spare_selector.sv
// Directed bench for tile_spare_selector; one task per scenario.
module tb_tile_spare_selector;
    localparam int K    = 2;
    localparam int TX   = 4;
    localparam int TY   = 4;
    localparam int COLS = TX * K;
    localparam int NT   = TX * TY;
    localparam int MW   = TY * K * COLS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [MW-1:0] defect_map = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [3:0]    out_tile;
    logic [1:0]    out_variant;
    logic          out_bad;
    logic          busy;
    logic          done;
    logic          any_fail;
    logic [4:0]    fail_count;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    tile_spare_selector #(.K(K), .TILES_X(TX), .TILES_Y(TY)) dut (
        .clk, .rst_n, .start, .defect_map, .out_valid, .out_ready,
        .out_tile, .out_variant, .out_bad, .busy, .done, .any_fail, .fail_count
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int bit_idx(input int t, input int p);
        return ((t / TX) * K + p / K) * COLS + (t % TX) * K + p % K;
    endfunction

    function automatic logic [MW-1:0] set_cell(input logic [MW-1:0] m, input int t, input int p);
        logic [MW-1:0] r = m;
        r[bit_idx(t, p)] = 1'b1;
        return r;
    endfunction

    // Expected result for tile t from the map, built from R3, R4, R5.
    task automatic expect_tile(input logic [MW-1:0] m, input int t,
                               output int var_e, output bit bad_e);
        int cnt = 0;
        int pos = 0;
        for (int p = 0; p < K*K; p++)
            if (m[bit_idx(t, p)]) begin
                if (cnt == 0) pos = p;
                cnt++;
            end
        bad_e = (cnt > 1);
        var_e = bad_e ? 0 : pos;
    endtask

    // Runs one scan and checks every result plus the final totals.
    task automatic run_scan(input logic [MW-1:0] m, input bit stall, input bit restart);
        int got = 0;
        int cyc = 0;
        int gaps = 0;
        int expfail = 0;
        bit held = 0;
        int h_tile = 0, h_var = 0, h_bad = 0;
        int ve;
        bit be;
        defect_map = m;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
        chk(done == 1'b0 && fail_count == 0 && any_fail == 1'b0, "R9",
            "cleared on start", int'(fail_count) + int'(done) + int'(any_fail), 0);
        while (!done && cyc < 400) begin
            out_ready = stall ? bit'(cyc % 2) : 1'b1;
            start = (restart && cyc == 3);
            if (out_valid) begin
                if (held)
                    chk(int'(out_tile) == h_tile && int'(out_variant) == h_var &&
                        int'(out_bad) == h_bad, "R6", "stalled result changed",
                        int'(out_tile), h_tile);
                if (out_ready) begin
                    expect_tile(m, got, ve, be);
                    chk(int'(out_tile) == got, "R2", "tile order", int'(out_tile), got);
                    chk(int'(out_variant) == ve, be ? "R5" : (ve == 0 ? "R4" : "R3"),
                        "variant", int'(out_variant), ve);
                    chk(out_bad == be, "R5", "bad flag", int'(out_bad), int'(be));
                    if (be) expfail++;
                    got++;
                    held = 0;
                end else begin
                    held = 1;
                    h_tile = int'(out_tile);
                    h_var = int'(out_variant);
                    h_bad = int'(out_bad);
                end
            end else if (got > 0 && got < NT && !stall) begin
                gaps++;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        out_ready = 1'b0;
        chk(got == NT, "R2", "tiles delivered", got, NT);
        if (!stall) chk(gaps == 0, "R10", "idle cycles between results", gaps, 0);
        chk(done == 1'b1 && busy == 1'b0, "R8", "done and idle at end",
            int'(done) * 2 + int'(busy), 2);
        chk(int'(fail_count) == expfail, "R7", "fail_count", int'(fail_count), expfail);
        chk(any_fail == (expfail > 0), "R7", "any_fail", int'(any_fail), int'(expfail > 0));
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !busy && !done && !any_fail && fail_count == 0, "R1",
            "reset state", int'(out_valid) + int'(busy) + int'(done) + int'(fail_count), 0);
    endtask

    task automatic test_clean();
        run_scan('0, 1'b0, 1'b0);      // R4, R10
    endtask

    task automatic test_single_each();
        logic [MW-1:0] m = '0;
        for (int t = 0; t < NT; t++) m = set_cell(m, t, (t + t / TX) % (K*K));
        run_scan(m, 1'b0, 1'b0);       // R3
    endtask

    task automatic test_multi_fault();
        logic [MW-1:0] m = '0;
        for (int t = 1; t < NT; t++) m = set_cell(m, t, t % (K*K));
        m = set_cell(m, 5, 0);
        for (int p = 0; p < K*K; p++) m = set_cell(m, 9, p);
        m = set_cell(m, 15, 2);
        run_scan(m, 1'b0, 1'b0);       // R5, R7: three bad tiles
    endtask

    task automatic test_backpressure();
        logic [MW-1:0] m = '0;
        for (int t = 0; t < NT; t += 2) m = set_cell(m, t, 3 - (t / 2) % 4);
        m = set_cell(m, 6, 1);
        run_scan(m, 1'b1, 1'b0);       // R6
    endtask

    task automatic test_restart_ignored();
        logic [MW-1:0] m = '0;
        m = set_cell(m, 3, 1);
        m = set_cell(m, 3, 2);
        m = set_cell(m, 12, 3);
        run_scan(m, 1'b0, 1'b1);       // R8 start while busy
        run_scan('0, 1'b0, 1'b0);      // R9 totals cleared on the next scan
    endtask

    initial begin
        test_reset();
        test_clean();
        test_single_each();
        test_multi_fault();
        test_backpressure();
        test_restart_ignored();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule